// File: doc/BRIEF.md
# Quarter-Resolution VGA Scan Timing Generator

This block produces the raster timing for a 640x480, 60 Hz-class VGA mode from a single 25 MHz pixel clock. It does all its counting in coarse units: one horizontal unit spans four pixel clocks and one vertical unit spans four scan lines. A framebuffer stored at a quarter of the screen resolution can therefore use the horizontal and vertical counts directly as column and row addresses. A third counter tracks every real scan line, for a text renderer that works at full vertical resolution.

Every timing edge comes from a set/reset flag. The flag flips when its counter reaches a fixed value. Horizontal blanking begins when the column count reaches its visible limit. The same event advances the scan-line bookkeeping, so the row address changes before the next row's first fetch. That happens earlier than the column wrap. The vertical sync pulse is two real lines long: it is released halfway through a single coarse row, using the upper bit of the line sub-counter.

An asynchronous active-low reset clears every counter. Reset is assumed to be released away from the clock edge. All outputs come from registers.

Top module: `vga_scan_gen`

## Requirements
- R1: While reset is low, `col`, `row` and `scan_line` are 0, `h_active`, `v_active` and `pix_active` are 1, and `hsync_n` and `vsync_n` are 1.
- R2: `col` advances by one on every fourth clock edge after reset release. The first step happens on the 4th edge. After 199 (`H_TOTAL-1`) it wraps to 0, giving 800 clocks per line.
- R3: `h_active` is 0 exactly while `col` is in 160..199 (`H_VIS` up to `H_TOTAL-1`), and 1 otherwise.
- R4: `hsync_n` is 0 exactly while `col` is in 164..187 (`H_SYNC_ON` up to `H_SYNC_OFF-1`), which is 96 clocks per line.
- R5: A line event occurs on the edge where `col` becomes 160. `row` advances on every fourth line event and wraps from `V_TOTAL-1` (default 130) to 0.
- R6: `v_active` is 0 exactly while `row` is in `V_VIS` up to `V_TOTAL-1` (default 120..130).
- R7: `vsync_n` goes to 0 on the line event that moves `row` to `V_SYNC_ON` (default 122). It returns to 1 two line events later, so it is low for the first two of that row's four lines.
- R8: `pix_active` equals `h_active` AND `v_active` on every cycle.
- R9: `scan_line` increments on every line event and returns to 0 on the event that wraps `row`, so it spans 0 to `4*V_TOTAL-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col | output | 8 | Coarse column address (4 clocks per step) |
| row | output | 8 | Coarse row address (4 lines per step) |
| scan_line | output | 10 | Real scan-line count within the frame |
| h_active | output | 1 | Horizontal visible window |
| v_active | output | 1 | Vertical visible window |
| pix_active | output | 1 | Both windows visible |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
On a single edge, the line event does several things together: it drops `h_active`, it steps the line sub-counter and `scan_line`, and, on every fourth line, it moves `row`. When `row` moves, `v_active` or `vsync_n` may change on that edge, or the frame may wrap. The bench shrinks the vertical parameters (visible 20, sync 22, total 25) so that it covers a whole frame and its wrap. A driver derives the expected state of every output after each edge from the edge count alone and queues it. A monitor compares the outputs against that state at the next falling edge. Any slip of the row, the vertical flags or the line counter against the horizontal blanking edge shows up in that exact cycle.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  localparam int unsigned DEF_DIV_W      = 2;
  localparam int unsigned DEF_X_W        = 8;
  localparam int unsigned DEF_H_VIS      = 160;
  localparam int unsigned DEF_H_SYNC_ON  = 164;
  localparam int unsigned DEF_H_SYNC_OFF = 188;
  localparam int unsigned DEF_H_TOTAL    = 200;
  localparam int unsigned DEF_Y_W        = 8;
  localparam int unsigned DEF_SUB_W      = 2;
  localparam int unsigned DEF_LINE_W     = 10;
  localparam int unsigned DEF_V_VIS      = 120;
  localparam int unsigned DEF_V_SYNC_ON  = 122;
  localparam int unsigned DEF_V_TOTAL    = 131;
endpackage

// File: rtl/scan_prescale.sv
module scan_prescale #(
  parameter int unsigned DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [DIV_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign tick = &cnt_q;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("tick on consecutive cycles"); // R2
endmodule

// File: rtl/scan_sr_flag.sv
module scan_sr_flag #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_nxt,
  output logic flag_q
);
  always_comb begin
    flag_nxt = flag_q;
    if (en) begin
      if (set_i)      flag_nxt = 1'b1;
      else if (clr_i) flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= RST_VAL;
    else        flag_q <= flag_nxt;
  end
endmodule

// File: rtl/vga_hscan.sv
module vga_hscan #(
  parameter int unsigned X_W        = 8,
  parameter int unsigned H_VIS      = 160,
  parameter int unsigned H_SYNC_ON  = 164,
  parameter int unsigned H_SYNC_OFF = 188,
  parameter int unsigned H_TOTAL    = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  output logic [X_W-1:0] x_o,
  output logic           h_de_o,
  output logic           h_de_nxt_o,
  output logic           hsync_n_o,
  output logic           line_evt_o
);
  localparam logic [X_W-1:0] X_LAST  = X_W'(H_TOTAL - 1);
  localparam logic [X_W-1:0] X_VIS   = X_W'(H_VIS);
  localparam logic [X_W-1:0] X_SON   = X_W'(H_SYNC_ON);
  localparam logic [X_W-1:0] X_SOFF  = X_W'(H_SYNC_OFF);
  localparam logic [X_W-1:0] X_TOTAL = X_W'(H_TOTAL);

  logic [X_W-1:0] x_q, x_nxt;
  logic           at_last, at_vis, at_son, at_soff;
  logic           hs_nxt_unused;

  always_comb begin
    at_last = (x_q == X_LAST);
    x_nxt   = x_q;
    if (tick_i) x_nxt = at_last ? '0 : x_q + 1'b1;
    at_vis  = tick_i && (x_nxt == X_VIS);
    at_son  = tick_i && (x_nxt == X_SON);
    at_soff = tick_i && (x_nxt == X_SOFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= '0;
    else        x_q <= x_nxt;
  end

  scan_sr_flag #(.RST_VAL(1'b1)) u_hde (
    .clk(clk), .rst_n(rst_n), .en(tick_i),
    .set_i(at_last), .clr_i(at_vis),
    .flag_nxt(h_de_nxt_o), .flag_q(h_de_o)
  );

  scan_sr_flag #(.RST_VAL(1'b1)) u_hsync (
    .clk(clk), .rst_n(rst_n), .en(tick_i),
    .set_i(at_soff), .clr_i(at_son),
    .flag_nxt(hs_nxt_unused), .flag_q(hsync_n_o)
  );

  assign x_o        = x_q;
  assign line_evt_o = at_vis;

  AST_X_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    x_q < X_TOTAL) else $error("column out of range"); // R2
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick_i) |-> (x_q == (($past(x_q) == X_LAST) ? '0 : $past(x_q) + 1'b1)))
    else $error("column step wrong"); // R2
  AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> $stable(x_q)) else $error("column moved without tick"); // R2
  AST_HDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    h_de_o == (x_q < X_VIS)) else $error("h_active window"); // R3
  AST_HSYNC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_n_o == !((x_q >= X_SON) && (x_q < X_SOFF))) else $error("hsync window"); // R4
endmodule

// File: rtl/vga_vscan.sv
module vga_vscan #(
  parameter int unsigned Y_W       = 8,
  parameter int unsigned SUB_W     = 2,
  parameter int unsigned LINE_W    = 10,
  parameter int unsigned V_VIS     = 120,
  parameter int unsigned V_SYNC_ON = 122,
  parameter int unsigned V_TOTAL   = 131
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_evt_i,
  output logic [Y_W-1:0]    y_o,
  output logic [LINE_W-1:0] line_o,
  output logic              v_de_o,
  output logic              v_de_nxt_o,
  output logic              vsync_n_o
);
  localparam logic [Y_W-1:0]    Y_LAST  = Y_W'(V_TOTAL - 1);
  localparam logic [Y_W-1:0]    Y_VIS   = Y_W'(V_VIS);
  localparam logic [Y_W-1:0]    Y_SON   = Y_W'(V_SYNC_ON);
  localparam logic [Y_W-1:0]    Y_TOTAL = Y_W'(V_TOTAL);
  localparam logic [LINE_W-1:0] L_TOTAL = LINE_W'(V_TOTAL << SUB_W);

  logic [SUB_W-1:0]  sub_q, sub_nxt;
  logic [Y_W-1:0]    y_q, y_nxt;
  logic [LINE_W-1:0] line_q, line_nxt;
  logic              row_adv, frame_wrap, half_row, vs_clr;
  logic              vs_nxt_unused;

  always_comb begin
    row_adv    = line_evt_i && (&sub_q);
    frame_wrap = row_adv && (y_q == Y_LAST);
    sub_nxt    = line_evt_i ? sub_q + 1'b1 : sub_q;
    y_nxt      = y_q;
    if (row_adv) y_nxt = frame_wrap ? '0 : y_q + 1'b1;
    line_nxt   = line_q;
    if (line_evt_i) line_nxt = frame_wrap ? '0 : line_q + 1'b1;
    half_row   = sub_nxt[SUB_W-1] && !sub_q[SUB_W-1];
    vs_clr     = row_adv && (y_nxt == Y_SON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      y_q    <= '0;
      line_q <= '0;
    end else begin
      sub_q  <= sub_nxt;
      y_q    <= y_nxt;
      line_q <= line_nxt;
    end
  end

  scan_sr_flag #(.RST_VAL(1'b1)) u_vde (
    .clk(clk), .rst_n(rst_n), .en(row_adv),
    .set_i(frame_wrap), .clr_i(y_nxt == Y_VIS),
    .flag_nxt(v_de_nxt_o), .flag_q(v_de_o)
  );

  scan_sr_flag #(.RST_VAL(1'b1)) u_vsync (
    .clk(clk), .rst_n(rst_n), .en(line_evt_i),
    .set_i(half_row), .clr_i(vs_clr),
    .flag_nxt(vs_nxt_unused), .flag_q(vsync_n_o)
  );

  assign y_o    = y_q;
  assign line_o = line_q;

  AST_Y_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    y_q < Y_TOTAL) else $error("row out of range"); // R5
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_evt_i) |-> $stable(y_q)) else $error("row moved without line event"); // R5
  AST_VDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    v_de_o == (y_q < Y_VIS)) else $error("v_active window"); // R6
  AST_VSYNC_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n_o |-> (y_q == Y_SON)) else $error("vsync outside its row"); // R7
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    line_q < L_TOTAL) else $error("scan line out of range"); // R9
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_evt_i) |-> $stable(line_q)) else $error("scan line moved"); // R9
endmodule

// File: rtl/vga_scan_gen.sv
module vga_scan_gen
  import vga_scan_pkg::*;
#(
  parameter int unsigned DIV_W      = DEF_DIV_W,
  parameter int unsigned X_W        = DEF_X_W,
  parameter int unsigned H_VIS      = DEF_H_VIS,
  parameter int unsigned H_SYNC_ON  = DEF_H_SYNC_ON,
  parameter int unsigned H_SYNC_OFF = DEF_H_SYNC_OFF,
  parameter int unsigned H_TOTAL    = DEF_H_TOTAL,
  parameter int unsigned Y_W        = DEF_Y_W,
  parameter int unsigned SUB_W      = DEF_SUB_W,
  parameter int unsigned LINE_W     = DEF_LINE_W,
  parameter int unsigned V_VIS      = DEF_V_VIS,
  parameter int unsigned V_SYNC_ON  = DEF_V_SYNC_ON,
  parameter int unsigned V_TOTAL    = DEF_V_TOTAL
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [X_W-1:0]    col,
  output logic [Y_W-1:0]    row,
  output logic [LINE_W-1:0] scan_line,
  output logic              h_active,
  output logic              v_active,
  output logic              pix_active,
  output logic              hsync_n,
  output logic              vsync_n
);
  logic tick, line_evt, h_de_nxt, v_de_nxt;
  logic de_q, de_nxt;

  scan_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  vga_hscan #(
    .X_W(X_W), .H_VIS(H_VIS), .H_SYNC_ON(H_SYNC_ON),
    .H_SYNC_OFF(H_SYNC_OFF), .H_TOTAL(H_TOTAL)
  ) u_h (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .x_o(col), .h_de_o(h_active), .h_de_nxt_o(h_de_nxt),
    .hsync_n_o(hsync_n), .line_evt_o(line_evt)
  );

  vga_vscan #(
    .Y_W(Y_W), .SUB_W(SUB_W), .LINE_W(LINE_W),
    .V_VIS(V_VIS), .V_SYNC_ON(V_SYNC_ON), .V_TOTAL(V_TOTAL)
  ) u_v (
    .clk(clk), .rst_n(rst_n), .line_evt_i(line_evt),
    .y_o(row), .line_o(scan_line), .v_de_o(v_active),
    .v_de_nxt_o(v_de_nxt), .vsync_n_o(vsync_n)
  );

  always_comb begin
    de_nxt = h_de_nxt && v_de_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) de_q <= 1'b1;
    else        de_q <= de_nxt;
  end

  assign pix_active = de_q;

  AST_DE_AND: assert property (@(posedge clk) disable iff (!rst_n)
    pix_active == (h_active && v_active)) else $error("pix_active mismatch"); // R8
endmodule

// File: tb/tb_vga_scan_gen.sv
module tb_vga_scan_gen;
  localparam int HV = 160, HSON = 164, HSOFF = 188, HT = 200;
  localparam int VV = 20, VSON = 22, VT = 25;
  localparam int RUN1 = VT * 4 * HT * 4 + 2000;
  localparam int RUN2 = 1700;

  typedef struct packed {
    logic [7:0] x;
    logic [7:0] y;
    logic [9:0] line;
    logic hde, vde, de, hs, vs;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] col, row;
  logic [9:0] scan_line;
  logic h_active, v_active, pix_active, hsync_n, vsync_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t expq[$];

  always #2 clk = ~clk;

  vga_scan_gen #(
    .V_VIS(VV), .V_SYNC_ON(VSON), .V_TOTAL(VT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .col(col), .row(row), .scan_line(scan_line),
    .h_active(h_active), .v_active(v_active), .pix_active(pix_active),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic exp_t exp_at(input int n);
    exp_t e;
    int xv, l, lf, yv;
    xv = (n / 4) % HT;
    l  = (n >= HV * 4) ? (n - HV * 4) / (HT * 4) + 1 : 0;
    lf = l % (VT * 4);
    yv = lf / 4;
    e.x    = 8'(xv);
    e.y    = 8'(yv);
    e.line = 10'(lf);
    e.hde  = (xv < HV);
    e.hs   = !((xv >= HSON) && (xv < HSOFF));
    e.vde  = (yv < VV);
    e.vs   = !((yv == VSON) && ((lf % 4) < 2));
    e.de   = e.hde && e.vde;
    return e;
  endfunction

  task automatic check_reset();
    chk("R1", "col", int'(col), 0);
    chk("R1", "row", int'(row), 0);
    chk("R1", "scan_line", int'(scan_line), 0);
    chk("R1", "h_active", int'(h_active), 1);
    chk("R1", "v_active", int'(v_active), 1);
    chk("R1", "pix_active", int'(pix_active), 1);
    chk("R1", "hsync_n", int'(hsync_n), 1);
    chk("R1", "vsync_n", int'(vsync_n), 1);
  endtask

  // driver: one expected item per clock edge after reset release
  task automatic drive(input int cycles);
    for (int n = 1; n <= cycles; n++) begin
      @(posedge clk);
      expq.push_back(exp_at(n));
    end
  endtask

  // monitor: compare outputs against the queued expectation
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      chk("R2", "col", int'(col), int'(e.x));
      chk("R3", "h_active", int'(h_active), int'(e.hde));
      chk("R4", "hsync_n", int'(hsync_n), int'(e.hs));
      chk("R5", "row", int'(row), int'(e.y));
      chk("R6", "v_active", int'(v_active), int'(e.vde));
      chk("R7", "vsync_n", int'(vsync_n), int'(e.vs));
      chk("R8", "pix_active", int'(pix_active), int'(e.de));
      chk("R9", "scan_line", int'(scan_line), int'(e.line));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    drive(RUN1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check_reset();
    repeat (2) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    drive(RUN2);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule